// File: doc/BRIEF.md
# Two-Phase Interleaved Full-Bridge Gate Generator

This block produces the switch drive for two full-bridge resonant converter stages from one system clock. Each bridge has two legs, and each leg has a high-side and a low-side gate. In each switching period a bridge first closes one diagonal pair (leg A high, leg B low) and then the other pair (leg A low, leg B high). Each pair is on for half the period. The second bridge uses the same period, but its pattern lags the first by exactly a quarter period. The two bridge outputs are therefore 90 degrees apart, which keeps the ripple on the shared output low.

Both bridges are timed by a single free-running counter. The period length and the dead time are given in clock cycles. A new period length takes effect only when the current period ends. After every pattern change, and after start-up, all gates of the affected bridge are held low for the programmed dead time. Dropping the enable turns every gate off in the same cycle. Raising it again starts both bridges at the top of a fresh period. At a 125 MHz clock, a period count of 1000 gives the nominal 125 kHz switching rate, slightly below a 130 kHz tank resonance.

Top module: `ifb_gate_gen`

## Requirements
- R1: While reset is active, or in any cycle in which `en` is low, all eight gate outputs are 0. Lowering `en` clears them in that same cycle, before any clock edge.
- R2: With the period count P latched, let c be the counter value (0..P-1), which advances by one per cycle. Bridge 1 drives `4'b1001` (bit0 leg A high-side, bit1 leg A low-side, bit2 leg B high-side, bit3 leg B low-side) for c < P/2 and `4'b0110` for P/2 <= c < P, apart from dead-time blanking.
- R3: Bridge 2 drives `4'b1001` for P/4 <= c < 3P/4 and `4'b0110` otherwise, apart from dead-time blanking, so that it lags bridge 1 by a quarter period.
- R4: The high-side gate and the low-side gate of the same leg are never high together.
- R5: After each change of a bridge's pattern, all four of that bridge's gates stay low for exactly D cycles, where D is `dead_cnt`. D = 0 gives no gap.
- R6: The cycle in which `en` is first seen high keeps all gates low. From the next edge on, the counter starts at c = 0, with bridge 1 at the top of its period and bridge 2 in its `4'b0110` half. Both bridges are blanked for the first D cycles.
- R7: A new `period_cnt` value is latched only when the counter wraps from P-1 to 0. The period that is running completes with its old length.
- R8: If `en` is removed in the middle of a period and then restored, the block restarts from c = 0 and does not continue from where it stopped.
- R9: `period_cnt` must be a multiple of 4 and at least 8, and `dead_cnt` must be less than a quarter of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low forces all gates off |
| period_cnt | input | CNT_W | Switching period in clock cycles |
| dead_cnt | input | DT_W | Dead time in clock cycles |
| p1_gate | output | 4 | Bridge 1 gates {B low, B high, A low, A high} |
| p2_gate | output | 4 | Bridge 2 gates, same bit order |

## Verification
Both bridges are compared with an independent model in every cycle. The runs cover a zero-dead-time pattern at P=16, a long period with a three-cycle dead time, and the smallest legal period with one cycle of dead time. Together these separate errors in the half-period edges, errors in the quarter-period offset, and errors in blanking length. In one run the period input changes in the middle of a period: the old length must finish before the new one appears. Another run removes the enable in the middle of a period and restores it, which shows whether the gates clear at once and whether the restart begins at a fresh period top rather than resuming.

// File: rtl/ifb_gate_gen.sv
module ifb_gate_gen #(
  parameter int CNT_W = 16,
  parameter int DT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] period_cnt,
  input  logic [DT_W-1:0]  dead_cnt,
  output logic [3:0]       p1_gate,
  output logic [3:0]       p2_gate
);

  localparam logic [3:0] PAT_POS = 4'b1001;
  localparam logic [3:0] PAT_NEG = 4'b0110;

  logic             run;
  logic [CNT_W-1:0] cnt, per_q;
  logic [CNT_W-1:0] half, qtr, tq;
  logic             h1, h2, h1_prev, h2_prev;
  logic [DT_W-1:0]  bl1, bl2;
  logic             gap1, gap2, last;
  logic [DT_W-1:0]  bl_load;

  assign half = per_q >> 1;
  assign qtr  = per_q >> 2;
  assign tq   = half + qtr;
  assign last = (cnt == per_q - 1'b1);

  assign h1 = (cnt < half);
  assign h2 = (cnt >= qtr) && (cnt < tq);

  assign bl_load = (dead_cnt == '0) ? '0 : dead_cnt - 1'b1;
  assign gap1 = (h1 != h1_prev) ? (dead_cnt != '0) : (bl1 != '0);
  assign gap2 = (h2 != h2_prev) ? (dead_cnt != '0) : (bl2 != '0);

  assign p1_gate = (en && run && !gap1) ? (h1 ? PAT_POS : PAT_NEG) : 4'b0000;
  assign p2_gate = (en && run && !gap2) ? (h2 ? PAT_POS : PAT_NEG) : 4'b0000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      cnt     <= '0;
      per_q   <= '0;
      h1_prev <= 1'b0;
      h2_prev <= 1'b0;
      bl1     <= '0;
      bl2     <= '0;
    end else if (!en) begin
      run <= 1'b0;
    end else if (!run) begin
      run     <= 1'b1;
      cnt     <= '0;
      per_q   <= period_cnt;
      h1_prev <= 1'b1;
      h2_prev <= 1'b0;
      bl1     <= dead_cnt;
      bl2     <= dead_cnt;
    end else begin
      if (last) begin
        cnt   <= '0;
        per_q <= period_cnt;
      end else begin
        cnt <= cnt + 1'b1;
      end
      h1_prev <= h1;
      h2_prev <= h2;
      if (h1 != h1_prev)   bl1 <= bl_load;
      else if (bl1 != '0) bl1 <= bl1 - 1'b1;
      if (h2 != h2_prev)   bl2 <= bl_load;
      else if (bl2 != '0) bl2 <= bl2 - 1'b1;
    end
  end

  AST_GATES_OFF_DIS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (p1_gate == 4'b0000 && p2_gate == 4'b0000)); // R1

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < per_q)); // R2

  AST_P2_QUARTER: assert property (@(posedge clk) disable iff (!rst_n)
    (p2_gate != 4'b0000) |-> (p2_gate[0] == ((cnt >= (per_q >> 2)) && (cnt < (per_q >> 2) + (per_q >> 1))))); // R3

  AST_LEG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(p1_gate[0] && p1_gate[1]) && !(p1_gate[2] && p1_gate[3]) &&
    !(p2_gate[0] && p2_gate[1]) && !(p2_gate[2] && p2_gate[3])); // R4

  AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dead_cnt) != '0 && $past(p1_gate) != 4'b0000 && p1_gate != 4'b0000)
      |-> (p1_gate == $past(p1_gate))); // R5

  AST_PER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && en && !last) |=> (per_q == $past(per_q))); // R7

endmodule

// File: tb/ifb_gate_gen_tb.sv
module ifb_gate_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] period_cnt = 16'd16;
  logic [7:0]  dead_cnt = 8'd0;
  logic [3:0]  p1_gate, p2_gate;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  ifb_gate_gen u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .period_cnt(period_cnt),
    .dead_cnt(dead_cnt), .p1_gate(p1_gate), .p2_gate(p2_gate)
  );

  function automatic logic [3:0] exp_gate(input int ph, input int c, input int P,
                                          input int D, input bit first);
    bit hi;
    int since;
    if (ph == 1) begin
      hi = (c < P/2);
      since = (c < P/2) ? c : c - P/2;
    end else begin
      hi = (c >= P/4) && (c < 3*P/4);
      if (c >= 3*P/4)   since = c - 3*P/4;
      else if (c >= P/4) since = c - P/4;
      else               since = first ? c : c + P/4;
    end
    if (since < D) return 4'b0000;
    return hi ? 4'b1001 : 4'b0110;
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  task automatic check_legs(input string req);
    n_chk++;
    if ((p1_gate[0] && p1_gate[1]) || (p1_gate[2] && p1_gate[3]) ||
        (p2_gate[0] && p2_gate[1]) || (p2_gate[2] && p2_gate[3])) begin
      n_bad++;
      $display("FAIL %s leg overlap: actual %b/%b expected no leg with both gates", req, p1_gate, p2_gate);
    end
  endtask

  task automatic run_span(input int P, input int D, input int k0, input int n, input string req);
    for (int k = k0; k < k0 + n; k++) begin
      @(posedge clk); #2;
      check({req, " bridge1"}, p1_gate, exp_gate(1, k % P, P, D, k < P));
      check({req, " bridge2"}, p2_gate, exp_gate(2, k % P, P, D, k < P));
      check_legs("R4");
    end
  endtask

  task automatic start(input int P, input int D);
    @(posedge clk); #2;
    period_cnt = 16'(P);
    dead_cnt = 8'(D);
    en = 1'b1;
    #1;
    check("R6 first-enable cycle bridge1", p1_gate, 4'b0000);
    check("R6 first-enable cycle bridge2", p2_gate, 4'b0000);
  endtask

  task automatic stop();
    @(posedge clk); #2;
    en = 1'b0;
    #1;
    check("R1 immediate off bridge1", p1_gate, 4'b0000);
    check("R1 immediate off bridge2", p2_gate, 4'b0000);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #2;
      check("R1 held off bridge1", p1_gate, 4'b0000);
      check("R1 held off bridge2", p2_gate, 4'b0000);
    end
  endtask

  task automatic t_reset();
    en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #2;
      check("R1 reset bridge1", p1_gate, 4'b0000);
      check("R1 reset bridge2", p2_gate, 4'b0000);
    end
    en = 1'b0;
    @(posedge clk); #2;
    rst_n = 1'b1;
  endtask

  task automatic t_basic();
    start(16, 0);
    run_span(16, 0, 0, 40, "R2/R3 P16 D0");
    stop();
  endtask

  task automatic t_dead();
    start(32, 3);
    run_span(32, 3, 0, 70, "R5/R6 P32 D3");
    stop();
  endtask

  task automatic t_restart();
    start(16, 2);
    run_span(16, 2, 0, 21, "R8 before stop");
    stop();
    start(16, 2);
    run_span(16, 2, 0, 20, "R8 fresh restart");
    stop();
  endtask

  task automatic t_period_change();
    start(16, 1);
    run_span(16, 1, 0, 6, "R7 old period");
    period_cnt = 16'd8;
    run_span(16, 1, 6, 10, "R7 old period held");
    run_span(8, 1, 8, 24, "R7 new period");
    stop();
  endtask

  task automatic t_min();
    start(8, 1);
    run_span(8, 1, 0, 24, "R9 P8 D1");
    stop();
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_dead();
    t_restart();
    t_period_change();
    t_min();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule